// File: doc/BRIEF.md
# TMDS Link Period Sequencer

This block decides, one character clock at a time, what each of the three channels of a TMDS-style video link carries. The encoders that follow it are out of scope. For every character it gives each channel a symbol class and the raw bits that the matching encoder needs. The classes are control, guard band, video and TERC4 nibble. It puts the eight-character preamble in front of every data period and adds the guard bands. It also keeps a minimum run of plain control characters between any two data periods.

Upstream timing logic sends requests one at a time. A request asks for either an active video line of N pixels or a data island of M packets, and its length field holds the count minus one. The block holds one request that it cannot yet start. It lowers `req_ready` while that request waits and raises `busy` until the work is finished. Requests start in the order they were accepted. While video characters go out, the block pulls pixel words through `pix_take`. While packet characters go out, it pulls one header bit and one byte of packet data through `pkt_take`.

Top module: `tmds_period_seq`

## Requirements
- R1: After reset the block is in a control period. CTL bits are zero, `busy` is 0 and `req_ready` is 1.
- R2: A symbol class is coded as 0 control, 1 guard, 2 video, 3 TERC4. Per channel, `sym_cls` uses bits [1:0] for channel 0, [3:2] for channel 1 and [5:4] for channel 2. `sym_bits` uses bytes [7:0], [15:8] and [23:16] in the same channel order. In a plain control character, channel 0 carries hsync in bit 0 and vsync in bit 1. Channels 1 and 2 carry zero.
- R3: A preamble is 8 control characters. Channel 1 carries CTL0 in bit 0 and CTL1 in bit 1. Channel 2 carries CTL2 in bit 0 and CTL3 in bit 1. CTL0..3 is 1,0,0,0 before video and 1,0,1,0 before an island. Channel 0 keeps following the live sync inputs.
- R4: A video period is 2 guard characters on all channels, with bits zero, followed by N video characters. Those carry `pix_data` bytes [7:0], [15:8] and [23:16] on channels 0, 1 and 2, and `pix_take` is high for exactly these characters. A control character follows directly, with no trailing guard.
- R5: A data island opens and closes with 2 guard characters. In each, channel 0 is TERC4 with bits {1,1,vsync,hsync} in bits 3..0, and channels 1 and 2 are guard class with zero bits.
- R6: An island carries 32·M packet characters, all TERC4. Channel 0 carries {mark,hdr,vsync,hsync} in bits 3..0, where mark is 0 on the first character of each packet and 1 elsewhere. Channel 1 carries `pkt_data[3:0]` and channel 2 carries `pkt_data[7:4]`. `pkt_take` is high for exactly these characters.
- R7: Every data period is followed by at least CTL_MIN plain control characters before the next preamble. The run is exactly CTL_MIN when a request is already waiting.
- R8: A request accepted while the block is idle, with the control run already long enough, starts its preamble two characters after the cycle in which it was offered.
- R9: `req_ready` is low exactly while a request is held. `busy` is high while a request is held or a period, including its preamble, is in progress. Held requests start in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low reset |
| hsync | input | 1 | Horizontal sync level |
| vsync | input | 1 | Vertical sync level |
| req_valid | input | 1 | Period request offered |
| req_island | input | 1 | 1 = data island, 0 = video line |
| req_len | input | LEN_W | Pixel or packet count minus one |
| req_ready | output | 1 | Request slot free |
| busy | output | 1 | Request held or period in progress |
| pix_data | input | 24 | Pixel word for the current character |
| pix_take | output | 1 | Pixel word consumed this character |
| pkt_hdr_bit | input | 1 | Packet-header bit for the current character |
| pkt_data | input | 8 | Packet-data bits for the current character |
| pkt_take | output | 1 | Packet bits consumed this character |
| sym_cls | output | 6 | Symbol class per channel |
| sym_bits | output | 24 | Raw encoder bits per channel |

## Verification
The bench sends a single video line of length 1 and of length 5, and single islands of one and of two packets. Comparing these shows whether the period lengths and the per-packet mark follow the length field, or are off by one. Back-to-back pairs, video then island and island then video, push the second request into the hold slot. These pairs show that the minimum control gap is counted from the end of a period, that the CTL code follows each request's own kind, and that `req_ready` and `busy` follow the held request. The sync inputs, pixel words and packet bits change on every character, so a mapping that lags by a cycle, or one that puts bits on the wrong channel, shows up.

// File: rtl/tmds_seq_pkg.sv
package tmds_seq_pkg;

    typedef enum logic [2:0] {
        PH_CTRL,
        PH_PRE,
        PH_VGB,
        PH_VID,
        PH_ILGB,
        PH_ISL,
        PH_ITGB
    } phase_e;

    typedef enum logic [1:0] {
        CLS_CTRL  = 2'd0,
        CLS_GUARD = 2'd1,
        CLS_VIDEO = 2'd2,
        CLS_TERC4 = 2'd3
    } sym_cls_e;

    localparam int PRE_LEN   = 8;
    localparam int GB_LEN    = 2;
    localparam int PKT_CHARS = 32;

endpackage

// File: rtl/tmds_req_slot.sv
module tmds_req_slot #(
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_island,
    input  logic [LEN_W-1:0] req_len,
    input  logic             take,
    output logic             ready,
    output logic             pend,
    output logic             pend_island,
    output logic [LEN_W-1:0] pend_len
);

    typedef struct packed {
        logic             full;
        logic             island;
        logic [LEN_W-1:0] len;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (take) begin
            s_d.full = 1'b0;
        end
        if (req_valid && !s_q.full) begin
            s_d.full   = 1'b1;
            s_d.island = req_island;
            s_d.len    = req_len;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ready       = !s_q.full;
    assign pend        = s_q.full;
    assign pend_island = s_q.island;
    assign pend_len    = s_q.len;

    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.full && !take) |=> (s_q.full && $stable(s_q.len) && $stable(s_q.island))); // R9

endmodule

// File: rtl/tmds_period_fsm.sv
module tmds_period_fsm
    import tmds_seq_pkg::*;
#(
    parameter int LEN_W   = 6,
    parameter int CTL_MIN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pend,
    input  logic             pend_island,
    input  logic [LEN_W-1:0] pend_len,
    output logic             take,
    output phase_e           phase,
    output logic [4:0]       pkt_pos,
    output logic             is_island
);

    localparam int CNT_W = LEN_W + 5;
    localparam int CC_W  = $clog2(CTL_MIN + 1);
    localparam logic [CC_W-1:0] CC_LAST = CC_W'(CTL_MIN - 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic [CC_W-1:0]  ctl_run;
        logic             island;
        logic [LEN_W-1:0] len;
    } fsm_t;

    fsm_t f_d, f_q;

    always_comb begin
        f_d  = f_q;
        take = 1'b0;
        f_d.cnt = f_q.cnt + CNT_W'(1);
        unique case (f_q.phase)
            PH_CTRL: begin
                f_d.cnt = '0;
                if (f_q.ctl_run != CC_LAST) f_d.ctl_run = f_q.ctl_run + CC_W'(1);
                if (pend && f_q.ctl_run == CC_LAST) begin
                    take       = 1'b1;
                    f_d.phase  = PH_PRE;
                    f_d.island = pend_island;
                    f_d.len    = pend_len;
                end
            end
            PH_PRE: if (f_q.cnt == CNT_W'(PRE_LEN - 1)) begin
                f_d.phase = f_q.island ? PH_ILGB : PH_VGB;
                f_d.cnt   = '0;
            end
            PH_VGB: if (f_q.cnt == CNT_W'(GB_LEN - 1)) begin
                f_d.phase = PH_VID;
                f_d.cnt   = '0;
            end
            PH_VID: if (f_q.cnt == CNT_W'(f_q.len)) begin
                f_d.phase   = PH_CTRL;
                f_d.cnt     = '0;
                f_d.ctl_run = '0;
            end
            PH_ILGB: if (f_q.cnt == CNT_W'(GB_LEN - 1)) begin
                f_d.phase = PH_ISL;
                f_d.cnt   = '0;
            end
            PH_ISL: if (f_q.cnt == {f_q.len, 5'h1f}) begin
                f_d.phase = PH_ITGB;
                f_d.cnt   = '0;
            end
            PH_ITGB: if (f_q.cnt == CNT_W'(GB_LEN - 1)) begin
                f_d.phase   = PH_CTRL;
                f_d.cnt     = '0;
                f_d.ctl_run = '0;
            end
            default: begin
                f_d.phase = PH_CTRL;
                f_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{phase: PH_CTRL, cnt: '0, ctl_run: '0, island: 1'b0, len: '0};
        else        f_q <= f_d;
    end

    assign phase     = f_q.phase;
    assign pkt_pos   = f_q.cnt[4:0];
    assign is_island = f_q.island;

    AST_PRE_TO_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.phase == PH_PRE && f_q.cnt == CNT_W'(PRE_LEN - 1)) |=> (f_q.phase inside {PH_VGB, PH_ILGB})); // R3
    AST_PRE_KIND_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.phase == PH_PRE && f_q.cnt != '0) |-> $stable(f_q.island)); // R3

endmodule

// File: rtl/tmds_sym_map.sv
module tmds_sym_map
    import tmds_seq_pkg::*;
(
    input  phase_e      phase,
    input  logic [4:0]  pkt_pos,
    input  logic        is_island,
    input  logic        hsync,
    input  logic        vsync,
    input  logic [23:0] pix_data,
    input  logic        pkt_hdr_bit,
    input  logic [7:0]  pkt_data,
    output logic [5:0]  sym_cls,
    output logic [23:0] sym_bits,
    output logic        pix_take,
    output logic        pkt_take
);

    sym_cls_e   c0, c1, c2;
    logic [7:0] b0, b1, b2;

    always_comb begin
        c0 = CLS_CTRL;  c1 = CLS_CTRL;  c2 = CLS_CTRL;
        b0 = {6'b0, vsync, hsync};
        b1 = 8'h00;
        b2 = 8'h00;
        pix_take = 1'b0;
        pkt_take = 1'b0;
        unique case (phase)
            PH_PRE: begin
                b1 = 8'h01;
                b2 = {7'b0, is_island};
            end
            PH_VGB: begin
                c0 = CLS_GUARD; c1 = CLS_GUARD; c2 = CLS_GUARD;
                b0 = 8'h00;
            end
            PH_VID: begin
                c0 = CLS_VIDEO; c1 = CLS_VIDEO; c2 = CLS_VIDEO;
                b0 = pix_data[7:0];
                b1 = pix_data[15:8];
                b2 = pix_data[23:16];
                pix_take = 1'b1;
            end
            PH_ILGB, PH_ITGB: begin
                c0 = CLS_TERC4; c1 = CLS_GUARD; c2 = CLS_GUARD;
                b0 = {4'b0, 2'b11, vsync, hsync};
            end
            PH_ISL: begin
                c0 = CLS_TERC4; c1 = CLS_TERC4; c2 = CLS_TERC4;
                b0 = {4'b0, (pkt_pos != 5'd0), pkt_hdr_bit, vsync, hsync};
                b1 = {4'b0, pkt_data[3:0]};
                b2 = {4'b0, pkt_data[7:4]};
                pkt_take = 1'b1;
            end
            default: ;
        endcase
        sym_cls  = {c2, c1, c0};
        sym_bits = {b2, b1, b0};
    end

endmodule

// File: rtl/tmds_period_seq.sv
module tmds_period_seq
    import tmds_seq_pkg::*;
#(
    parameter int LEN_W   = 6,
    parameter int CTL_MIN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync,
    input  logic             vsync,
    input  logic             req_valid,
    input  logic             req_island,
    input  logic [LEN_W-1:0] req_len,
    output logic             req_ready,
    output logic             busy,
    input  logic [23:0]      pix_data,
    output logic             pix_take,
    input  logic             pkt_hdr_bit,
    input  logic [7:0]       pkt_data,
    output logic             pkt_take,
    output logic [5:0]       sym_cls,
    output logic [23:0]      sym_bits
);

    logic             take, pend, pend_island, is_island;
    logic [LEN_W-1:0] pend_len;
    logic [4:0]       pkt_pos;
    phase_e           phase;

    tmds_req_slot #(.LEN_W(LEN_W)) u_slot (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_island(req_island), .req_len(req_len),
        .take(take), .ready(req_ready),
        .pend(pend), .pend_island(pend_island), .pend_len(pend_len)
    );

    tmds_period_fsm #(.LEN_W(LEN_W), .CTL_MIN(CTL_MIN)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .pend(pend), .pend_island(pend_island), .pend_len(pend_len),
        .take(take), .phase(phase), .pkt_pos(pkt_pos), .is_island(is_island)
    );

    tmds_sym_map u_map (
        .phase(phase), .pkt_pos(pkt_pos), .is_island(is_island),
        .hsync(hsync), .vsync(vsync),
        .pix_data(pix_data), .pkt_hdr_bit(pkt_hdr_bit), .pkt_data(pkt_data),
        .sym_cls(sym_cls), .sym_bits(sym_bits),
        .pix_take(pix_take), .pkt_take(pkt_take)
    );

    assign busy = pend || (phase != PH_CTRL);

    AST_CTL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sym_cls[1:0]) != CLS_CTRL && sym_cls[1:0] == CLS_CTRL) |-> (sym_bits[23:8] == 16'h0)); // R7
    AST_PIX_ONLY_VIDEO: assert property (@(posedge clk) disable iff (!rst_n)
        pix_take |-> (sym_cls == {CLS_VIDEO, CLS_VIDEO, CLS_VIDEO})); // R4
    AST_GUARD_BEFORE_VIDEO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pix_take) |-> ($past(sym_cls[3:2]) == CLS_GUARD)); // R4
    AST_PKT_TERC4: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_take |-> (sym_cls == {CLS_TERC4, CLS_TERC4, CLS_TERC4})); // R6
    AST_HELD_IS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> busy); // R9

endmodule

// File: tb/tb_tmds_period_seq.sv
module tb_tmds_period_seq;

    localparam int LEN_W   = 6;
    localparam int CTL_MIN = 4;
    localparam int E_CTL = 0, E_PREV = 1, E_PREI = 2, E_VGB = 3, E_IGB = 4, E_VID = 5, E_PKT = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hsync = 1'b0, vsync = 1'b0;
    logic req_valid = 1'b0, req_island = 1'b0;
    logic [LEN_W-1:0] req_len = '0;
    logic req_ready, busy, pix_take, pkt_take, pkt_hdr_bit = 1'b0;
    logic [23:0] pix_data = '0;
    logic [7:0]  pkt_data = '0;
    logic [5:0]  sym_cls;
    logic [23:0] sym_bits;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [31:0] t = 0;
    logic r_v = 0, r_i = 0;
    logic [LEN_W-1:0] r_l = '0;

    always #5 clk = ~clk;

    tmds_period_seq #(.LEN_W(LEN_W), .CTL_MIN(CTL_MIN)) dut (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
        .req_valid(req_valid), .req_island(req_island), .req_len(req_len),
        .req_ready(req_ready), .busy(busy),
        .pix_data(pix_data), .pix_take(pix_take),
        .pkt_hdr_bit(pkt_hdr_bit), .pkt_data(pkt_data), .pkt_take(pkt_take),
        .sym_cls(sym_cls), .sym_bits(sym_bits)
    );

    task automatic step(input int mode, input bit eb, input bit er, input string tag, input bit first = 1'b0);
        logic [5:0]  ec;
        logic [23:0] eby;
        logic [33:0] got, exp;
        logic ept, ekt;
        @(negedge clk);
        t = t + 1;
        hsync       = t[0];
        vsync       = t[1];
        pix_data    = {t[7:0], ~t[7:0], t[7:0] ^ 8'hA5};
        pkt_hdr_bit = t[2] ^ t[4];
        pkt_data    = 8'(t * 13);
        req_valid   = r_v;
        req_island  = r_i;
        req_len     = r_l;
        #1;
        ec  = 6'b000000;
        eby = {16'h0, 6'b0, vsync, hsync};
        ept = 1'b0;
        ekt = 1'b0;
        case (mode)
            E_PREV: eby[15:8] = 8'h01;
            E_PREI: begin eby[15:8] = 8'h01; eby[23:16] = 8'h01; end
            E_VGB:  begin ec = 6'b010101; eby = 24'h0; end
            E_IGB:  begin ec = 6'b010111; eby = {16'h0, 4'b0, 2'b11, vsync, hsync}; end
            E_VID:  begin ec = 6'b101010; eby = pix_data; ept = 1'b1; end
            E_PKT:  begin
                ec  = 6'b111111;
                eby = {4'b0, pkt_data[7:4], 4'b0, pkt_data[3:0], 4'b0, ~first, pkt_hdr_bit, vsync, hsync};
                ekt = 1'b1;
            end
            default: ;
        endcase
        exp = {ec, eby, ept, ekt, eb, er};
        got = {sym_cls, sym_bits, pix_take, pkt_take, busy, req_ready};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s t=%0d got %h exp %h", tag, t, got, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(E_CTL, 1'b0, 1'b1, "R2 plain control");
    endtask

    task automatic pre(input bit isl, input bit er);
        for (int i = 0; i < 8; i++) step(isl ? E_PREI : E_PREV, 1'b1, er, "R3 preamble");
    endtask

    task automatic vbody(input int len, input bit er);
        for (int i = 0; i < 2; i++) step(E_VGB, 1'b1, er, "R4 video guard");
        for (int i = 0; i <= len; i++) step(E_VID, 1'b1, er, "R4 video data");
    endtask

    task automatic ibody(input int len, input bit er);
        for (int i = 0; i < 2; i++) step(E_IGB, 1'b1, er, "R5 island lead guard");
        for (int i = 0; i < (len + 1) * 32; i++) step(E_PKT, 1'b1, er, "R6 packet", (i % 32) == 0);
        for (int i = 0; i < 2; i++) step(E_IGB, 1'b1, er, "R5 island trail guard");
    endtask

    task automatic single(input bit isl, input int len);
        r_v = 1; r_i = isl; r_l = LEN_W'(len);
        step(E_CTL, 1'b0, 1'b1, "R8 offer");
        r_v = 0;
        step(E_CTL, 1'b1, 1'b0, "R9 held one char");
        pre(isl, 1'b1);
        if (isl) ibody(len, 1'b1);
        else     vbody(len, 1'b1);
        idle(CTL_MIN + 2);
    endtask

    task automatic pair(input bit isl1, input int l1, input bit isl2, input int l2);
        r_v = 1; r_i = isl1; r_l = LEN_W'(l1);
        step(E_CTL, 1'b0, 1'b1, "R8 offer first");
        r_i = isl2; r_l = LEN_W'(l2);
        step(E_CTL, 1'b1, 1'b0, "R9 slot full");
        step(isl1 ? E_PREI : E_PREV, 1'b1, 1'b1, "R9 slot freed");
        r_v = 0;
        for (int i = 1; i < 8; i++) step(isl1 ? E_PREI : E_PREV, 1'b1, 1'b0, "R3 preamble first");
        if (isl1) ibody(l1, 1'b0);
        else      vbody(l1, 1'b0);
        for (int i = 0; i < CTL_MIN; i++) step(E_CTL, 1'b1, 1'b0, "R7 control gap");
        pre(isl2, 1'b1);
        if (isl2) ibody(l2, 1'b1);
        else      vbody(l2, 1'b1);
        idle(CTL_MIN + 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(E_CTL, 1'b0, 1'b1, "R1 reset state");
        idle(CTL_MIN + 2);
        single(1'b0, 0);
        single(1'b0, 4);
        single(1'b1, 0);
        single(1'b1, 1);
        pair(1'b0, 2, 1'b1, 1);
        pair(1'b1, 0, 1'b0, 0);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule